// File: doc/BRIEF.md
# Serial Data-Link Controller Control Register

This block holds the 8-bit control register of a variable-pulse-width serial data-link controller and the logic that gates status updates and the CPU interrupt. The CPU writes and reads the register through a simple port. The register has four fields: a message-ignore flag, a link-clock select, an interrupt enable and a wait-clock mode. The clock select and the wait mode are driven out to the timing and power logic.

The block takes single-cycle event strobes from the receiver and the protocol state machine: start-of-frame, break, wakeup, receiver-error flush and generic status-update requests. When the ignore flag is set, generic status updates are blocked until the hardware clears the flag on the next start-of-frame or break. Wakeup and flush events always pass. The interrupt request is the interrupt enable ANDed with the OR of the pending flags reported by the status logic. This result is registered.

Top module: `vpw_ctl_reg`

## Requirements
- R1: After a synchronous reset the register reads 0x00, and `irq`, `clk_sel_bin` and `wait_clk_mode` are all 0.
- R2: The register has a fixed bit layout: bit 7 is ignore-message, bit 6 is clock select, bit 1 is interrupt enable and bit 0 is wait-clock mode. Bits 5 to 2 always read 0, and writes to them have no effect.
- R3: Clock select is write-once. The first CPU write after reset loads bit 6, and later writes leave that bit unchanged while still updating the other fields. Only reset releases the lock.
- R4: Interrupt enable and wait-clock mode take the written value on every write. `clk_sel_bin` shows clock select: 1 selects the 1.048576 MHz link clock and 0 selects the 1 MHz link clock. `wait_clk_mode` shows bit 0.
- R5: While ignore-message is set, a generic status request leaves `stat_upd_ok` low. While the flag is clear, `stat_upd_ok` follows `stat_req` in the same cycle.
- R6: A start-of-frame or break strobe clears ignore-message at the next clock edge. If a CPU write in the same cycle tries to set the flag, the clear wins.
- R7: Once set, ignore-message stays set until a start-of-frame, a break or a CPU write clears it, so the rest of the message stays masked. The mask still applies during the cycle that carries the start-of-frame.
- R8: A wakeup or receiver-error-flush strobe drives `stat_upd_ok` high in the same cycle, whatever the state of ignore-message.
- R9: `irq` equals interrupt enable AND (OR of `src_pend`), one clock later. Setting ignore-message does not drop `irq` while a pending flag remains. Clearing interrupt enable drops `irq` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register read value |
| rx_sof | input | 1 | Start-of-frame detected strobe |
| rx_break | input | 1 | Break symbol detected strobe |
| rx_wakeup | input | 1 | Wakeup event strobe |
| rx_err_flush | input | 1 | Receiver error that flushed a pending transmit byte |
| stat_req | input | 1 | Generic status-update request |
| src_pend | input | NSRC | Pending interrupt flags from the status logic |
| stat_upd_ok | output | 1 | Status register may update this cycle |
| clk_sel_bin | output | 1 | Link clock select (1 = 1.048576 MHz, 0 = 1 MHz) |
| wait_clk_mode | output | 1 | Wait-clock mode setting |
| irq | output | 1 | Registered CPU interrupt request |

## Verification
Several properties are checked by assertions on every cycle:
- the clock-select lock, once taken, keeps the bit stable;
- a start-of-frame or break always leaves ignore-message clear;
- the flag holds while no clearing event or write arrives;
- masked generic requests are never granted;
- the bypass events are always granted;
- a cleared enable silences the interrupt one cycle later.

Other behaviours can only be shown by the bench's directed scenarios:
- the exact read-back values, including the reserved bits;
- the first-write-wins rule across a reset;
- the priority of the auto-clear over a simultaneous CPU write;
- the one-cycle interrupt latency when pending flags and enable change.

// File: rtl/vpw_ctl_pkg.sv
package vpw_ctl_pkg;

    localparam int REG_W   = 8;
    localparam int BIT_IGN = 7;
    localparam int BIT_CLK = 6;
    localparam int BIT_IE  = 1;
    localparam int BIT_WCM = 0;

    typedef struct packed {
        logic ign;
        logic clk_sel;
        logic ie;
        logic wcm;
    } ctl_t;

    typedef struct packed {
        logic sof;
        logic brk;
        logic wake;
        logic flush;
        logic req;
    } evt_t;

    function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
        logic [REG_W-1:0] r;
        r          = '0;
        r[BIT_IGN] = c.ign;
        r[BIT_CLK] = c.clk_sel;
        r[BIT_IE]  = c.ie;
        r[BIT_WCM] = c.wcm;
        return r;
    endfunction

    function automatic logic evt_resync(input evt_t e);
        return e.sof | e.brk;
    endfunction

    function automatic logic evt_bypass(input evt_t e);
        return e.wake | e.flush;
    endfunction

endpackage

// File: rtl/vpw_ctl_fields.sv
module vpw_ctl_fields
    import vpw_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             resync,
    output ctl_t             ctl
);
    ctl_t ctl_q;
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            if (wr_en) begin
                ctl_q.ie  <= wdata[BIT_IE];
                ctl_q.wcm <= wdata[BIT_WCM];
                if (!lock_q) begin
                    ctl_q.clk_sel <= wdata[BIT_CLK];
                    lock_q        <= 1'b1;
                end
            end
            if (resync)
                ctl_q.ign <= 1'b0;
            else if (wr_en)
                ctl_q.ign <= wdata[BIT_IGN];
        end
    end

    assign ctl = ctl_q;

    AST_CLKSEL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(ctl_q.clk_sel)); // R3
    AST_IGN_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
        resync |=> !ctl_q.ign); // R6
    AST_IGN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ign && !resync && !wr_en) |=> ctl_q.ign); // R7

endmodule

// File: rtl/vpw_ctl_gate.sv
module vpw_ctl_gate
    import vpw_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ign,
    input  evt_t evt,
    output logic upd_ok
);
    logic generic_ok;

    always_comb begin
        generic_ok = evt.req & ~ign;
        upd_ok     = generic_ok | evt_bypass(evt);
    end

    AST_MASKED_REQ: assert property (@(posedge clk) disable iff (rst)
        (ign && !evt.wake && !evt.flush) |-> !upd_ok); // R5
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (evt.wake || evt.flush) |-> upd_ok); // R8

endmodule

// File: rtl/vpw_ctl_irq.sv
module vpw_ctl_irq #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ie,
    input  logic [NSRC-1:0] pend,
    output logic            irq
);
    logic [NSRC:0] any_chain;
    logic          irq_q;

    assign any_chain[0] = 1'b0;
    for (genvar i = 0; i < NSRC; i++) begin : g_or
        assign any_chain[i+1] = any_chain[i] | pend[i];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= ie & any_chain[NSRC];
    end

    assign irq = irq_q;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !ie |=> !irq); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> !irq); // R9

endmodule

// File: rtl/vpw_ctl_reg.sv
module vpw_ctl_reg
    import vpw_ctl_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cpu_wr,
    input  logic [7:0]      cpu_wdata,
    output logic [7:0]      cpu_rdata,
    input  logic            rx_sof,
    input  logic            rx_break,
    input  logic            rx_wakeup,
    input  logic            rx_err_flush,
    input  logic            stat_req,
    input  logic [NSRC-1:0] src_pend,
    output logic            stat_upd_ok,
    output logic            clk_sel_bin,
    output logic            wait_clk_mode,
    output logic            irq
);
    evt_t evt;
    ctl_t ctl;

    assign evt = '{sof: rx_sof, brk: rx_break, wake: rx_wakeup,
                   flush: rx_err_flush, req: stat_req};

    vpw_ctl_fields u_fields (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cpu_wr),
        .wdata  (cpu_wdata),
        .resync (evt_resync(evt)),
        .ctl    (ctl)
    );

    vpw_ctl_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .ign    (ctl.ign),
        .evt    (evt),
        .upd_ok (stat_upd_ok)
    );

    vpw_ctl_irq #(.NSRC(NSRC)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .ie   (ctl.ie),
        .pend (src_pend),
        .irq  (irq)
    );

    assign cpu_rdata     = ctl_pack(ctl);
    assign clk_sel_bin   = ctl.clk_sel;
    assign wait_clk_mode = ctl.wcm;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (cpu_rdata == 8'h00 && !irq)); // R1

endmodule

// File: tb/vpw_ctl_reg_bench.sv
`timescale 1ns/1ps
module vpw_ctl_reg_bench;
    localparam int NSRC = 4;

    logic clk = 1'b0;
    logic rst, cpu_wr, rx_sof, rx_break, rx_wakeup, rx_err_flush, stat_req;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic [NSRC-1:0] src_pend;
    logic stat_upd_ok, clk_sel_bin, wait_clk_mode, irq;
    int total = 0, bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    vpw_ctl_reg #(.NSRC(NSRC)) u_vpw_ctl_reg (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        wr(8'hC3);
        src_pend = '1;
        do_reset();
        chk("R1 rdata", cpu_rdata, 8'h00);
        chk("R1 irq/clk/wcm", {5'b0, irq, clk_sel_bin, wait_clk_mode}, 8'h00);
        src_pend = '0;
    endtask

    task automatic t_layout();
        do_reset();
        wr(8'hFF);
        chk("R2 all ones", cpu_rdata, 8'hC3);
        wr(8'h3C);
        chk("R2 reserved ignored", cpu_rdata, 8'h40);
    endtask

    task automatic t_clksel();
        do_reset();
        wr(8'h40);
        chk("R3 first write", cpu_rdata, 8'h40);
        chk("R4 clk_sel_bin", {7'b0, clk_sel_bin}, 8'h01);
        wr(8'h03);
        chk("R3 locked, others update", cpu_rdata, 8'h43);
        chk("R4 wait_clk_mode", {7'b0, wait_clk_mode}, 8'h01);
        do_reset();
        wr(8'h00);
        wr(8'h40);
        chk("R3 lock after zero write", {7'b0, clk_sel_bin}, 8'h00);
        wr(8'h01);
        chk("R4 wcm any time", cpu_rdata, 8'h01);
    endtask

    task automatic t_ignore();
        do_reset();
        @(negedge clk); stat_req = 1'b1; #1;
        chk("R5 clear passes", {7'b0, stat_upd_ok}, 8'h01);
        wr(8'h80);
        #1 chk("R5 masked", {7'b0, stat_upd_ok}, 8'h00);
        cyc_n(5);
        chk("R7 held", cpu_rdata, 8'h80);
        rx_sof = 1'b1; #1;
        chk("R7 masked in sof cycle", {7'b0, stat_upd_ok}, 8'h00);
        @(negedge clk); rx_sof = 1'b0; #1;
        chk("R6 sof clears", cpu_rdata, 8'h00);
        chk("R5 granted after sof", {7'b0, stat_upd_ok}, 8'h01);
        stat_req = 1'b0;
        wr(8'h80);
        rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
        chk("R6 break clears", cpu_rdata, 8'h00);
        cpu_wr = 1'b1; cpu_wdata = 8'h80; rx_break = 1'b1;
        @(negedge clk); cpu_wr = 1'b0; rx_break = 1'b0;
        chk("R6 autoclear beats write", cpu_rdata, 8'h00);
    endtask

    task automatic t_bypass();
        do_reset();
        wr(8'h80);
        rx_wakeup = 1'b1; #1;
        chk("R8 wakeup bypass", {7'b0, stat_upd_ok}, 8'h01);
        rx_wakeup = 1'b0; rx_err_flush = 1'b1; #1;
        chk("R8 flush bypass", {7'b0, stat_upd_ok}, 8'h01);
        rx_err_flush = 1'b0; #1;
        chk("R8 idle masked", {7'b0, stat_upd_ok}, 8'h00);
    endtask

    task automatic t_irq();
        do_reset();
        src_pend = 4'b0001;
        cyc_n(2);
        chk("R9 ie off", {7'b0, irq}, 8'h00);
        wr(8'h02);
        chk("R9 latency", {7'b0, irq}, 8'h00);
        @(negedge clk);
        chk("R9 asserted", {7'b0, irq}, 8'h01);
        wr(8'h82);
        @(negedge clk);
        chk("R9 ignore keeps irq", {7'b0, irq}, 8'h01);
        src_pend = '0;
        @(negedge clk);
        chk("R9 drops when clear", {7'b0, irq}, 8'h00);
        src_pend = 4'b1000;
        @(negedge clk);
        chk("R9 high source", {7'b0, irq}, 8'h01);
        wr(8'h00);
        @(negedge clk);
        chk("R9 ie cleared", {7'b0, irq}, 8'h00);
        src_pend = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpu_wr = 1'b0; cpu_wdata = '0; rx_sof = 1'b0; rx_break = 1'b0;
        rx_wakeup = 1'b0; rx_err_flush = 1'b0; stat_req = 1'b0; src_pend = '0;
        cyc_n(2);
        t_reset();
        t_layout();
        t_clksel();
        t_ignore();
        t_bypass();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule